// File: doc/BRIEF.md
# Sound RAM Manual Transfer Port

This block is the register-mapped window through which a host processor fills a 512 KiB sound sample memory one halfword at a time. The host first writes a start position, given in units of 8 bytes, into an address register. Each following write to the data port places one halfword in the sample memory at an internal byte pointer and moves that pointer forward by two bytes. The pointer wraps within the memory. The address register reads back the value that was programmed, never the advanced pointer.

A control register holds a 2-bit transfer mode in bits [5:4]. The encodings are 0 stopped, 1 manual write, 2 DMA write and 3 DMA read. The mode drives the DMA request line directly. A read-only status register completes the set. Host accesses may be 16-bit or 32-bit wide. A 32-bit access acts as two halfword accesses: the low half at the given offset first, then the high half at offset+2. Both halves complete in the same clock cycle, in that order. Read data is registered.

Top module: `snd_xfer_port`

## Requirements
- R1: While reset is held and just after it is released, `dma_req`, `ram_we` and `host_rdata` are 0, and reads of the address (0x1A6), control (0x1AA) and status (0x1AE) registers return 0.
- R2: A write to offset 0x1A6 stores the 16-bit value, and reads of 0x1A6 return that value unchanged even after data-port writes have advanced the pointer.
- R3: The first data-port write (offset 0x1A8) after an address write of value A produces, one cycle after the write, a single-cycle `ram_we` with `ram_addr` = A*8 and `ram_wdata` equal to the written halfword.
- R4: Each further data-port write lands 2 bytes above the previous one.
- R5: The byte pointer wraps modulo 0x80000: after address 0xFFFF, writes land at 0x7FFF8, 0x7FFFA, 0x7FFFC, 0x7FFFE and then 0x00000.
- R6: Reads of the data port and of any unmapped offset return 0xFFFF.
- R7: The control register (0x1AA) stores all 16 bits and reads them back unchanged.
- R8: One cycle after a control write, `dma_req` is 1 if control bits [5:4] are 2 or 3, and 0 if they are 0 or 1.
- R9: The status register reads 0, and writes to it leave it unchanged and produce no RAM write.
- R10: With `host_wide` set, the low 16 data bits act on the given offset and the high 16 bits act on offset+2, low half first. A wide read returns {value at offset+2, value at offset}. A narrow read returns 0 in bits [31:16].
- R11: `host_rdata` takes the read result in the cycle after `host_rd` is sampled and holds its value in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_off | input | 10 | Byte offset of the access within the block |
| host_rd | input | 1 | Read strobe |
| host_wr | input | 1 | Write strobe (takes priority over read) |
| host_wide | input | 1 | 32-bit access, split into two halfwords |
| host_wdata | input | 32 | Write data; the upper half is used only when wide |
| host_rdata | output | 32 | Registered read data |
| ram_we | output | 1 | Sample memory write enable |
| ram_addr | output | 19 | Sample memory byte address |
| ram_wdata | output | 16 | Sample memory write halfword |
| dma_req | output | 1 | DMA request derived from the transfer mode |

## Verification
The hardest case to reach is a 32-bit access whose two halves touch different registers in one cycle. An example is an address reload followed at once by a data write that must use the new pointer. The stimulus issues wide writes at 0x1A6 and at 0x1A8, so that address-then-data and data-then-control pairs both occur. A wide read at 0x1A8 then pairs the all-ones data port with the control value. Pointer wrap needs the top address 0xFFFF followed by five data writes, and the stimulus programs exactly that.

// File: rtl/snd_xfer_pkg.sv
package snd_xfer_pkg;
    localparam int OFF_W        = 10;
    localparam int HW_W         = 16;
    localparam int RAM_AW       = 19;
    localparam int UNIT_SHIFT   = 3;
    localparam int MODE_LSB     = 4;
    localparam int STEP_BYTES   = 2;

    localparam logic [OFF_W-1:0] OFF_ADDR = 10'h1A6;
    localparam logic [OFF_W-1:0] OFF_DATA = 10'h1A8;
    localparam logic [OFF_W-1:0] OFF_CTRL = 10'h1AA;
    localparam logic [OFF_W-1:0] OFF_STAT = 10'h1AE;

    typedef enum logic [1:0] {
        XM_STOP   = 2'd0,
        XM_MANUAL = 2'd1,
        XM_DMA_WR = 2'd2,
        XM_DMA_RD = 2'd3
    } xfer_mode_e;

    typedef struct packed {
        logic [HW_W-1:0]   addr_reg;
        logic [RAM_AW-1:0] ptr;
        logic [HW_W-1:0]   ctrl;
        logic [HW_W-1:0]   stat;
    } regs_t;
endpackage

// File: rtl/snd_xfer_hw_apply.sv
module snd_xfer_hw_apply
    import snd_xfer_pkg::*;
(
    input  logic              en,
    input  logic [OFF_W-1:0]  off,
    input  logic [HW_W-1:0]   wdata,
    input  regs_t             cur,
    output regs_t             nxt,
    output logic              we,
    output logic [RAM_AW-1:0] waddr,
    output logic [HW_W-1:0]   wval
);
    localparam logic [RAM_AW-1:0] STEP = RAM_AW'(STEP_BYTES);

    always_comb begin
        nxt   = cur;
        we    = 1'b0;
        waddr = cur.ptr;
        wval  = wdata;
        if (en) begin
            unique case (off)
                OFF_ADDR: begin
                    nxt.addr_reg = wdata;
                    nxt.ptr      = RAM_AW'({wdata, {UNIT_SHIFT{1'b0}}});
                end
                OFF_DATA: begin
                    we      = 1'b1;
                    nxt.ptr = cur.ptr + STEP;
                end
                OFF_CTRL: nxt.ctrl = wdata;
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/snd_xfer_rd_mux.sv
module snd_xfer_rd_mux
    import snd_xfer_pkg::*;
(
    input  logic [OFF_W-1:0] off,
    input  regs_t            cur,
    output logic [HW_W-1:0]  rdata
);
    always_comb begin
        unique case (off)
            OFF_ADDR: rdata = cur.addr_reg;
            OFF_CTRL: rdata = cur.ctrl;
            OFF_STAT: rdata = cur.stat;
            default:  rdata = {HW_W{1'b1}};
        endcase
    end
endmodule

// File: rtl/snd_xfer_port.sv
module snd_xfer_port
    import snd_xfer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OFF_W-1:0]  host_off,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic              host_wide,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              ram_we,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [HW_W-1:0]   ram_wdata,
    output logic              dma_req
);
    localparam int HALVES = 2;

    typedef struct packed {
        regs_t             regs;
        logic [31:0]       rdata;
        logic              we;
        logic [RAM_AW-1:0] waddr;
        logic [HW_W-1:0]   wval;
        logic              req;
    } state_t;

    state_t d, q;

    regs_t             stage   [HALVES+1];
    logic              st_we   [HALVES];
    logic [RAM_AW-1:0] st_addr [HALVES];
    logic [HW_W-1:0]   st_val  [HALVES];
    logic [HW_W-1:0]   rd_half [HALVES];

    assign stage[0] = q.regs;

    for (genvar g = 0; g < HALVES; g++) begin : g_half
        logic [OFF_W-1:0] h_off;
        logic             h_en;
        assign h_off = host_off + OFF_W'(g * STEP_BYTES);
        assign h_en  = host_wr && ((g == 0) || host_wide);

        snd_xfer_hw_apply u_apply (
            .en    (h_en),
            .off   (h_off),
            .wdata (host_wdata[g*HW_W +: HW_W]),
            .cur   (stage[g]),
            .nxt   (stage[g+1]),
            .we    (st_we[g]),
            .waddr (st_addr[g]),
            .wval  (st_val[g])
        );

        snd_xfer_rd_mux u_rd (
            .off   (h_off),
            .cur   (q.regs),
            .rdata (rd_half[g])
        );
    end

    always_comb begin
        xfer_mode_e mode;
        d      = q;
        d.regs = stage[HALVES];
        d.we   = 1'b0;
        for (int i = 0; i < HALVES; i++) begin
            if (st_we[i]) begin
                d.we    = 1'b1;
                d.waddr = st_addr[i];
                d.wval  = st_val[i];
            end
        end
        if (host_rd && !host_wr) begin
            d.rdata = {host_wide ? rd_half[1] : {HW_W{1'b0}}, rd_half[0]};
        end
        mode  = xfer_mode_e'(d.regs.ctrl[MODE_LSB +: 2]);
        d.req = (mode == XM_DMA_WR) || (mode == XM_DMA_RD);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign host_rdata = q.rdata;
    assign ram_we     = q.we;
    assign ram_addr   = q.waddr;
    assign ram_wdata  = q.wval;
    assign dma_req    = q.req;
endmodule

// File: rtl/snd_xfer_chk.sv
module snd_xfer_chk
    import snd_xfer_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [OFF_W-1:0]  host_off,
    input logic              host_rd,
    input logic              host_wr,
    input logic              host_wide,
    input logic [31:0]       host_wdata,
    input logic [31:0]       host_rdata,
    input logic              ram_we,
    input logic [RAM_AW-1:0] ram_addr,
    input logic              dma_req
);
    // R3
    ram_we_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> $past(host_wr));

    // R4
    ram_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && $past(ram_we) && $past(host_off) == OFF_DATA && !$past(host_wide)
         && $past(host_off, 2) == OFF_DATA && !$past(host_wide, 2))
        |-> ram_addr == $past(ram_addr) + RAM_AW'(STEP_BYTES));

    // R8
    dma_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(host_wr && !host_wide && host_off == OFF_CTRL)
        |-> dma_req == $past(host_wdata[MODE_LSB+1]));

    // R8
    dma_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(host_wr) |-> $stable(dma_req));

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(host_rd) |-> $stable(host_rdata));

    // R10
    narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(host_rd && !host_wr && !host_wide) |-> host_rdata[31:16] == 16'h0);
endmodule

bind snd_xfer_port snd_xfer_chk u_chk (.*);

// File: tb/snd_xfer_port_tb.sv
module snd_xfer_port_tb;
    import snd_xfer_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [OFF_W-1:0]  host_off = '0;
    logic              host_rd = 1'b0;
    logic              host_wr = 1'b0;
    logic              host_wide = 1'b0;
    logic [31:0]       host_wdata = '0;
    logic [31:0]       host_rdata;
    logic              ram_we;
    logic [RAM_AW-1:0] ram_addr;
    logic [HW_W-1:0]   ram_wdata;
    logic              dma_req;

    always #2.5 clk = ~clk;

    snd_xfer_port u_dut (.*);

    int n_chk = 0;
    int n_fail = 0;

    logic [HW_W-1:0]   m_areg = '0;
    logic [RAM_AW-1:0] m_ptr = '0;
    logic [HW_W-1:0]   m_ctrl = '0;

    logic [RAM_AW+HW_W-1:0] ram_q [$];
    string                  ram_tag_q [$];
    logic [31:0]            rd_q [$];
    string                  rd_tag_q [$];

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [HW_W-1:0] mdl_rd(logic [OFF_W-1:0] off);
        case (off)
            OFF_ADDR: return m_areg;
            OFF_CTRL: return m_ctrl;
            OFF_STAT: return 16'h0;
            default:  return 16'hFFFF;
        endcase
    endfunction

    task automatic mdl_wr(logic [OFF_W-1:0] off, logic [HW_W-1:0] v, string tag);
        case (off)
            OFF_ADDR: begin m_areg = v; m_ptr = {v, 3'b000}; end
            OFF_DATA: begin
                ram_q.push_back({m_ptr, v});
                ram_tag_q.push_back(tag);
                m_ptr = m_ptr + 19'd2;
            end
            OFF_CTRL: m_ctrl = v;
            default: ;
        endcase
    endtask

    task automatic wr(logic [OFF_W-1:0] off, logic [31:0] v, bit wide, string tag);
        @(negedge clk); #0.5;
        mdl_wr(off, v[15:0], tag);
        if (wide) mdl_wr(off + 10'd2, v[31:16], tag);
        host_off = off; host_wdata = v; host_wide = wide;
        host_wr = 1'b1; host_rd = 1'b0;
    endtask

    task automatic rd(logic [OFF_W-1:0] off, bit wide, string tag);
        @(negedge clk); #0.5;
        rd_q.push_back({wide ? mdl_rd(off + 10'd2) : 16'h0, mdl_rd(off)});
        rd_tag_q.push_back(tag);
        host_off = off; host_wide = wide;
        host_wr = 1'b0; host_rd = 1'b1;
    endtask

    task automatic idle();
        @(negedge clk); #0.5;
        host_wr = 1'b0; host_rd = 1'b0; host_wide = 1'b0;
    endtask

    // Monitor: at each falling edge the inputs still show what the last rising edge sampled.
    always @(negedge clk) begin
        if (rst_n) begin
            if (host_rd && !host_wr) begin
                if (rd_q.size() == 0) check("R11 unexpected read", 32'h1, 32'h0);
                else check(rd_tag_q.pop_front(), host_rdata, rd_q.pop_front());
            end
            if (ram_we) begin
                if (ram_q.size() == 0) check("R9 unexpected ram write", {13'h0, ram_addr}, 32'h0);
                else check(ram_tag_q.pop_front(), {ram_addr, ram_wdata}, ram_q.pop_front());
            end
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 dma_req in reset", {31'h0, dma_req}, 32'h0);
        check("R1 ram_we in reset", {31'h0, ram_we}, 32'h0);
        check("R1 rdata in reset", host_rdata, 32'h0);
        #0.5 rst_n = 1'b1;
        rd(OFF_ADDR, 0, "R1 addr after reset");
        rd(OFF_CTRL, 0, "R1 ctrl after reset");
        rd(OFF_STAT, 0, "R1 stat after reset");
        idle();
        // R11 hold: rdata keeps last value (0 from stat) with no read
        idle();
        check("R11 hold", host_rdata, 32'h0);

        // R2 R3 R4
        wr(OFF_ADDR, 32'h0000_0123, 0, "R2");
        wr(OFF_DATA, 32'h0000_AAAA, 0, "R3 first write");
        wr(OFF_DATA, 32'h0000_BBBB, 0, "R4 step");
        wr(OFF_DATA, 32'h0000_CCCC, 0, "R4 step");
        rd(OFF_ADDR, 0, "R2 readback");
        idle();

        // R5 wrap
        wr(OFF_ADDR, 32'h0000_FFFF, 0, "R5");
        for (int i = 0; i < 5; i++) wr(OFF_DATA, 32'h1000 + i, 0, "R5 wrap");
        rd(OFF_ADDR, 0, "R5 addr readback");

        // R6
        rd(OFF_DATA, 0, "R6 data port read");
        rd(10'h000, 0, "R6 unmapped");
        rd(10'h1AC, 0, "R6 unmapped");

        // R7 R8
        wr(OFF_CTRL, 32'h0000_C0A5, 0, "R7");
        idle();
        check("R8 mode 2", {31'h0, dma_req}, 32'h1);
        rd(OFF_CTRL, 0, "R7 readback");
        wr(OFF_CTRL, 32'h0000_0030, 0, "R8");
        idle();
        check("R8 mode 3", {31'h0, dma_req}, 32'h1);
        wr(OFF_CTRL, 32'h0000_FF10, 0, "R8");
        idle();
        check("R8 mode 1", {31'h0, dma_req}, 32'h0);
        wr(OFF_CTRL, 32'h0000_FFCF, 0, "R8");
        idle();
        check("R8 mode 0", {31'h0, dma_req}, 32'h0);
        rd(OFF_CTRL, 0, "R7 readback 2");

        // R9
        wr(OFF_STAT, 32'h0000_1234, 0, "R9");
        rd(OFF_STAT, 0, "R9 stat read");
        idle();

        // R10 wide: address then data in one access
        wr(OFF_ADDR, 32'h5A5A_0010, 1, "R10 addr+data");
        wr(OFF_DATA, 32'h0020_7777, 1, "R10 data+ctrl");
        idle();
        check("R10 high half ctrl dma", {31'h0, dma_req}, 32'h1);
        rd(OFF_DATA, 1, "R10 wide read data+ctrl");
        rd(OFF_ADDR, 1, "R10 wide read addr+data");
        rd(OFF_ADDR, 0, "R10 narrow read");
        idle();
        idle();
        check("R3 queue drained", ram_q.size(), 32'h0);
        check("R11 queue drained", rd_q.size(), 32'h0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule